// File: doc/BRIEF.md
# Positive-Sequence Dual SOGI Prefilter

This block cleans up the stationary-frame voltage seen by a grid synchronisation loop. Each sample strobe delivers the alpha and beta components of a three-phase voltage. The block runs one adaptive second-order generalized integrator on each axis. Each integrator produces an in-phase output and a quadrature output. A quadrature-combining stage then forms the fundamental positive-sequence alpha and beta components.

The resonant frequency of both integrators is not fixed. It is taken on every sample from an angular-frequency estimate that the downstream tracking loop supplies. The damping factor is fixed at 0.7. Positive-sequence input at the tuned frequency passes unchanged. Negative-sequence input at that frequency is cancelled, and harmonics are attenuated. When the estimate is wrong, the output shifts in phase by a predictable slope, which the downstream loop can compensate.

Top module: `pos_seq_prefilter`

## Requirements
- R1: With the frequency input at 50 Hz, a balanced positive-sequence 50 Hz input of 0.8 or 1.2 pu appears at the outputs with unity gain and no phase shift. The alpha output follows A·cos θ and the beta output follows A·sin θ, within 6 % of A in steady state.
- R2: With the frequency input at 50 Hz, a balanced 50 Hz negative-sequence input (alpha = A·cos θ, beta = −A·sin θ) leaves a steady-state residual below 3 % of A on both outputs.
- R3: With the frequency input at 50 Hz, a negative-sequence fifth harmonic or a positive-sequence seventh harmonic leaves a residual below 20 % of its amplitude on both outputs.
- R4: The centre frequency follows the frequency input. With both the input and the estimate at 55 Hz, positive sequence passes as in R1 and negative sequence is rejected as in R2.
- R5: With the estimate at 50 Hz and the input at 55 Hz or 45 Hz, the outputs follow A·cos(θ − φ) and A·sin(θ − φ), where φ = 0.004333 rad per rad/s of (input − estimate) frequency. The tolerance is 10 % of A.
- R6: `out_valid` is high for exactly one clock, two clocks after each `in_stb`. The outputs and the integrator states change only in response to a strobe.
- R7: A synchronous reset clears all integrator states and both outputs, and drops `out_valid`. After a reset, zero input keeps the outputs at zero.
- R8: A constant input of ±1.2 pu on alpha (beta = 0) settles to an alpha output of 0 and a beta output of ±0.84 pu (0.7·v), with no wrap-around.
- R9: The samples are signed 16-bit values with 1.0 pu = 8192, scaled the same way at the outputs. The frequency input is unsigned, in rad/s with 6 fraction bits (50 Hz = 20106). The sample rate is 10 kHz.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_stb | input | 1 | One-clock strobe marking a new sample |
| alpha_in | input | 16 | Alpha voltage sample, signed, 8192 = 1 pu |
| beta_in | input | 16 | Beta voltage sample, signed, 8192 = 1 pu |
| w_est | input | 16 | Estimated angular frequency, rad/s with 6 fraction bits |
| out_valid | output | 1 | One-clock strobe, new outputs present |
| alpha_pos | output | 16 | Positive-sequence alpha component |
| beta_pos | output | 16 | Positive-sequence beta component |

## Verification
Balanced positive-sequence sinusoids at two amplitudes show that the pass path has unity gain and zero phase. The matching negative-sequence sinusoid shows that the quadrature combination cancels rather than merely filters. Fifth and seventh harmonic sequences measure how much of the band-pass roll-off survives. Runs at 55 Hz with a matching estimate show that tuning follows the frequency input. Runs at 55 Hz and 45 Hz against a 50 Hz estimate show the sign and slope of the phase error that the downstream loop compensates. A ±1.2 pu constant drives the quadrature integrator to its largest steady value, so wrap-around would be seen there.

// File: rtl/pos_seq_prefilter.sv
module pos_seq_prefilter #(
  parameter int DW         = 16,
  parameter int FRAC_GUARD = 8,
  parameter int WW         = 16,
  parameter int W_FRAC     = 6,
  parameter int FS_HZ      = 10000,
  parameter int COEF_FRAC  = 30,
  parameter int GAIN_FRAC  = 14,
  parameter int DAMP_Q     = 11469
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_stb,
  input  logic signed [DW-1:0] alpha_in,
  input  logic signed [DW-1:0] beta_in,
  input  logic        [WW-1:0] w_est,
  output logic                 out_valid,
  output logic signed [DW-1:0] alpha_pos,
  output logic signed [DW-1:0] beta_pos
);

  localparam int     SW    = DW + FRAC_GUARD;
  localparam int     PW    = 64;
  localparam longint STEPK = ((64'sd1 <<< COEF_FRAC) + ((64'(FS_HZ) <<< W_FRAC) / 2))
                             / (64'(FS_HZ) <<< W_FRAC);
  localparam longint KGAIN = 2 * longint'(DAMP_Q);
  localparam longint SMAX  = (64'sd1 <<< (SW - 1)) - 1;
  localparam longint SMIN  = -(64'sd1 <<< (SW - 1));
  localparam longint OMAX  = (64'sd1 <<< (DW - 1)) - 1;
  localparam longint OMIN  = -(64'sd1 <<< (DW - 1));

  function automatic logic signed [SW-1:0] sat_st(input logic signed [PW-1:0] x);
    if (x > SMAX)      return SMAX[SW-1:0];
    else if (x < SMIN) return SMIN[SW-1:0];
    else               return x[SW-1:0];
  endfunction

  function automatic logic signed [DW-1:0] sat_out(input logic signed [PW-1:0] x);
    if (x > OMAX)      return OMAX[DW-1:0];
    else if (x < OMIN) return OMIN[DW-1:0];
    else               return x[DW-1:0];
  endfunction

  logic signed [PW-1:0] w_ext, step;
  assign w_ext = PW'(w_est);
  assign step  = w_ext * STEPK;

  for (genvar g = 0; g < 2; g++) begin : ax
    logic signed [DW-1:0] v;
    logic signed [SW-1:0] d_r, q_r, d_nx, q_nx;
    logic signed [PW-1:0] v_s, err;

    assign v    = (g == 0) ? alpha_in : beta_in;
    assign v_s  = PW'(v) <<< FRAC_GUARD;
    assign err  = (((v_s - PW'(d_r)) * KGAIN) >>> GAIN_FRAC) - PW'(q_r);
    assign d_nx = sat_st(PW'(d_r) + ((step * err) >>> COEF_FRAC));
    assign q_nx = sat_st(PW'(q_r) + ((step * PW'(d_nx)) >>> COEF_FRAC));

    always_ff @(posedge clk) begin
      if (rst) begin
        d_r <= '0;
        q_r <= '0;
      end else if (in_stb) begin
        d_r <= d_nx;
        q_r <= q_nx;
      end
    end
  end

  logic stb_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      stb_d     <= 1'b0;
      out_valid <= 1'b0;
      alpha_pos <= '0;
      beta_pos  <= '0;
    end else begin
      stb_d     <= in_stb;
      out_valid <= stb_d;
      if (stb_d) begin
        alpha_pos <= sat_out((PW'(ax[0].d_r) - PW'(ax[1].q_r)) >>> (FRAC_GUARD + 1));
        beta_pos  <= sat_out((PW'(ax[0].q_r) + PW'(ax[1].d_r)) >>> (FRAC_GUARD + 1));
      end
    end
  end

endmodule

// File: rtl/pos_seq_prefilter_chk.sv
module pos_seq_prefilter_chk #(
  parameter int DW = 16,
  parameter int SW = 24
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 in_stb,
  input logic                 out_valid,
  input logic signed [DW-1:0] alpha_pos,
  input logic signed [DW-1:0] beta_pos,
  input logic signed [SW-1:0] d_a,
  input logic signed [SW-1:0] q_a,
  input logic signed [SW-1:0] d_b,
  input logic signed [SW-1:0] q_b
);

  assert_valid_latency_R6: assert property (@(posedge clk) disable iff (rst)
    in_stb |=> ##1 out_valid);

  assert_valid_source_R6: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(in_stb, 2));

  assert_output_hold_R6: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> ($stable(alpha_pos) && $stable(beta_pos)));

  assert_state_hold_R6: assert property (@(posedge clk) disable iff (rst)
    !in_stb |=> ($stable(d_a) && $stable(q_a) && $stable(d_b) && $stable(q_b)));

  assert_reset_clear_R7: assert property (@(posedge clk)
    $past(rst) |-> (!out_valid && alpha_pos == 0 && beta_pos == 0 &&
                    d_a == 0 && q_a == 0 && d_b == 0 && q_b == 0));

endmodule

bind pos_seq_prefilter pos_seq_prefilter_chk #(.DW(DW), .SW(DW + FRAC_GUARD)) u_chk (
  .clk(clk), .rst(rst), .in_stb(in_stb), .out_valid(out_valid),
  .alpha_pos(alpha_pos), .beta_pos(beta_pos),
  .d_a(ax[0].d_r), .q_a(ax[0].q_r), .d_b(ax[1].d_r), .q_b(ax[1].q_r)
);

// File: tb/pos_seq_prefilter_test.sv
`timescale 1ns/1ps
module pos_seq_prefilter_test;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_stb = 1'b0;
  logic signed [15:0] alpha_in = '0;
  logic signed [15:0] beta_in = '0;
  logic [15:0] w_est = '0;
  logic out_valid;
  logic signed [15:0] alpha_pos, beta_pos;

  always #2.5 clk = ~clk;

  pos_seq_prefilter uut (
    .clk(clk), .rst(rst), .in_stb(in_stb), .alpha_in(alpha_in), .beta_in(beta_in),
    .w_est(w_est), .out_valid(out_valid), .alpha_pos(alpha_pos), .beta_pos(beta_pos)
  );

  localparam real PU     = 8192.0;
  localparam real TWO_PI = 6.283185307179586;

  // kind 1: expect fundamental (with lag model), kind 0: expect zero residual
  typedef struct packed {
    int h; int amp_m; int fin; int fest; int kind; int tol_m;
  } vec_t;

  localparam vec_t VEC [0:8] = '{
    '{ 1,  800, 50, 50, 1,  60},
    '{ 1, 1200, 50, 50, 1,  60},
    '{-1, 1000, 50, 50, 0,  30},
    '{-5,  500, 50, 50, 0, 200},
    '{ 7,  500, 50, 50, 0, 200},
    '{ 1, 1000, 55, 55, 1,  60},
    '{-1, 1000, 55, 55, 0,  30},
    '{ 1, 1000, 55, 50, 1, 100},
    '{ 1, 1000, 45, 50, 1, 100}
  };
  localparam string TAG [0:8] = '{"R1", "R1 R8", "R2", "R3", "R3", "R4", "R4", "R5", "R5"};

  int  n_checks = 0;
  int  n_fail = 0;
  bit  done = 1'b0;
  longint sidx = 0;

  task automatic check(input bit ok, input string req, input real act, input real exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual %f expected %f", req, act, exp);
    end
  endtask

  function automatic logic signed [15:0] q16(input real x);
    int v;
    v = $rtoi(x * PU + ((x >= 0.0) ? 0.5 : -0.5));
    return v[15:0];
  endfunction

  function automatic logic [15:0] wq(input real hz);
    int v;
    v = $rtoi(TWO_PI * hz * 64.0 + 0.5);
    return v[15:0];
  endfunction

  task automatic sample(input logic signed [15:0] a, input logic signed [15:0] b);
    @(negedge clk);
    alpha_in = a;
    beta_in  = b;
    in_stb   = 1'b1;
    @(negedge clk);
    in_stb   = 1'b0;
    @(negedge clk);
  endtask

  function automatic real absr(input real x);
    return (x < 0.0) ? -x : x;
  endfunction

  initial begin
    #1_000_000;
    if (!done) begin
      n_fail++;
      n_checks++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    real  ea, eb, th, xa, xb, amp, lag, ya, yb, tol;
    logic signed [15:0] ha, hb;

    w_est = wq(50.0);
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R7: reset state
    check(out_valid == 1'b0, "R7 valid after reset", real'(out_valid), 0.0);
    check(alpha_pos == 0 && beta_pos == 0, "R7 outputs after reset",
          real'(alpha_pos) + real'(beta_pos), 0.0);

    // R6: latency of exactly two clocks, single-clock pulse
    alpha_in = q16(0.5);
    beta_in  = '0;
    in_stb   = 1'b1;
    @(negedge clk);
    in_stb = 1'b0;
    check(out_valid == 1'b0, "R6 valid one clock after strobe", real'(out_valid), 0.0);
    @(negedge clk);
    check(out_valid == 1'b1, "R6 valid two clocks after strobe", real'(out_valid), 1.0);
    @(negedge clk);
    check(out_valid == 1'b0, "R6 valid pulse width", real'(out_valid), 0.0);

    // Main table (R1..R5, R9 scaling)
    for (int i = 0; i < 9; i++) begin
      amp   = VEC[i].amp_m / 1000.0;
      tol   = VEC[i].tol_m / 1000.0 * amp;
      lag   = 0.004333 * TWO_PI * real'(VEC[i].fin - VEC[i].fest);
      w_est = wq(real'(VEC[i].fest));
      ea = 0.0;
      eb = 0.0;
      for (int k = 0; k < 750; k++) begin
        th = TWO_PI * real'(VEC[i].fin) * real'(sidx) / 10000.0;
        sidx++;
        sample(q16(amp * $cos(real'(VEC[i].h) * th)), q16(amp * $sin(real'(VEC[i].h) * th)));
        if (k >= 500) begin
          xa = (VEC[i].kind == 1) ? amp * $cos(th - lag) : 0.0;
          xb = (VEC[i].kind == 1) ? amp * $sin(th - lag) : 0.0;
          ya = real'(alpha_pos) / PU;
          yb = real'(beta_pos) / PU;
          if (absr(ya - xa) > ea) ea = absr(ya - xa);
          if (absr(yb - xb) > eb) eb = absr(yb - xb);
        end
      end
      check(ea <= tol, {TAG[i], " alpha max error"}, ea, tol);
      check(eb <= tol, {TAG[i], " beta max error"}, eb, tol);
    end

    // R6: inputs without a strobe have no effect on the outputs
    ha = alpha_pos;
    hb = beta_pos;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      alpha_in = q16(1.1);
      beta_in  = q16(-1.1);
    end
    check(alpha_pos == ha && beta_pos == hb, "R6 outputs held without strobe",
          real'(alpha_pos), real'(ha));
    check(out_valid == 1'b0, "R6 no valid without strobe", real'(out_valid), 0.0);

    // R7: mid-run reset clears states
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    check(alpha_pos == 0 && beta_pos == 0 && out_valid == 1'b0, "R7 reset mid-run",
          real'(alpha_pos) + real'(beta_pos), 0.0);
    sample('0, '0);
    check(alpha_pos == 0 && beta_pos == 0, "R7 zero input after reset keeps zero output",
          real'(alpha_pos) + real'(beta_pos), 0.0);

    // R8: constant +-1.2 pu, beta output settles to 0.7 * v without wrap
    w_est = wq(50.0);
    for (int s = 0; s < 2; s++) begin
      xa = (s == 0) ? 1.2 : -1.2;
      for (int k = 0; k < 500; k++) sample(q16(xa), '0);
      ya = real'(alpha_pos) / PU;
      yb = real'(beta_pos) / PU;
      check(absr(ya) <= 0.02, "R8 alpha output for constant input", ya, 0.0);
      check(absr(yb - 0.7 * xa) <= 0.02, "R8 beta output for constant input", yb, 0.7 * xa);
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule